// File: doc/BRIEF.md
# Accumulator Arithmetic and Logic Unit with Status Flags

This block is the arithmetic and logic stage of an 8-bit accumulator machine. Each cycle it takes the current accumulator value, a second operand byte, a carry input, the present four-bit flag nibble and a four-bit operation code. It produces the new accumulator byte, a write-back strobe that tells the register file whether to store that byte, and the updated zero, subtract, half-carry and carry flags.

Each operation has its own flag rule. The half-carry flag comes from the nibble boundary. Compare, set-carry and complement-carry change only the flags. The decimal-adjust operation uses the subtract flag to decide whether it corrects after an addition or after a subtraction. All outputs are registered, so results appear one clock after the inputs. Operand fetch, the register file and memory access belong to neighbouring blocks.

Top module: `acc_alu`

## Requirements
- R1: Codes 0 (add) and 1 (add with carry, which adds `carry_in`) write back the 8-bit sum. They set Z when the sum is zero, clear N, set H on a carry out of bit 3 and set C on a carry out of bit 7. The flag nibble is laid out as bit 3 = Z, bit 2 = N, bit 1 = H, bit 0 = C, on input and on output.
- R2: Codes 2 (subtract) and 3 (subtract with borrow, which also subtracts `carry_in`) write back the difference modulo 256. They set N, set Z when the difference is zero, set H when the low nibble of the subtrahend (plus the carry) exceeds the low nibble of the accumulator, and set C when the subtrahend (plus the carry) exceeds the accumulator.
- R3: Code 4 (compare) produces the same flags as code 2. It holds the write-back strobe low and presents the unchanged accumulator on `result`.
- R4: Codes 5, 6 and 7 (AND, OR, XOR) write back the bitwise result with Z following the result, N=0 and C=0. H is 1 for AND and 0 for OR and XOR.
- R5: Codes 8 (increment) and 9 (decrement) act on the accumulator and write it back. Z follows the result. H marks a carry out of bit 3 for increment and a borrow from bit 4 for decrement. N is 0 for increment and 1 for decrement. C keeps its input value.
- R6: Code 10 writes back the bitwise inverse of the accumulator, sets N and H, and keeps Z and C.
- R7: Code 11 forces C to 1 and code 12 inverts C. Both clear N and H, keep Z, hold the write-back strobe low and present the unchanged accumulator.
- R8: Code 13 with N clear (after an addition) adds 0x06 when H is set or the low nibble exceeds 9. It adds 0x60 and sets C when C is set or the accumulator exceeds 0x99, and otherwise keeps C. It writes back the result, clears H, keeps N and sets Z from the result.
- R9: Code 13 with N set (after a subtraction) subtracts 0x06 when H is set and 0x60 when C is set. It keeps C and N, clears H, sets Z from the result and writes back.
- R10: Codes 14 and 15 present the accumulator and the input flags unchanged, with the write-back strobe low.
- R11: While `rst` is high at a clock edge, the next outputs are result 0, write-back low and all flags 0.
- R12: All outputs reflect the inputs sampled at the previous rising clock edge, which is a latency of one cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op | input | 4 | Operation code |
| acc_in | input | 8 | Accumulator value |
| opnd_in | input | 8 | Second operand |
| carry_in | input | 1 | Carry used by add-with-carry and subtract-with-borrow |
| flags_in | input | 4 | Current flags {Z,N,H,C} |
| result | output | 8 | Registered result byte |
| wr_en | output | 1 | Registered accumulator write-back strobe |
| flags_out | output | 4 | Registered new flags {Z,N,H,C} |

## Verification
The assertions assume the operation code and operands are stable for the full clock period that they are sampled over. They also assume a reset pulse lasts at least one edge, because every property compares an output with the inputs one edge earlier. The stimulus changes inputs only on falling edges. It sweeps every accumulator value against a set of corner operands for the two-operand codes, and every accumulator value against all sixteen flag nibbles for the single-operand codes. Every input combination is therefore a legal, settled one.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;
  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_ADC  = 4'd1,
    OP_SUB  = 4'd2,
    OP_SBC  = 4'd3,
    OP_CMP  = 4'd4,
    OP_AND  = 4'd5,
    OP_OR   = 4'd6,
    OP_XOR  = 4'd7,
    OP_INC  = 4'd8,
    OP_DEC  = 4'd9,
    OP_CPL  = 4'd10,
    OP_SCF  = 4'd11,
    OP_CCF  = 4'd12,
    OP_DAA  = 4'd13
  } alu_op_e;

  localparam int FLG_Z = 3;
  localparam int FLG_N = 2;
  localparam int FLG_H = 1;
  localparam int FLG_C = 0;
endpackage

// File: rtl/acc_alu_addsub.sv
module acc_alu_addsub #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  input  logic         sub,
  output logic [W-1:0] sum,
  output logic         half,
  output logic         carry
);
  localparam int HW = W / 2;

  logic [W:0]  full_w;
  logic [HW:0] low_w;

  always_comb begin
    if (sub) begin
      full_w = {1'b0, a} - {1'b0, b} - {{W{1'b0}}, cin};
      low_w  = {1'b0, a[HW-1:0]} - {1'b0, b[HW-1:0]} - {{HW{1'b0}}, cin};
    end else begin
      full_w = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};
      low_w  = {1'b0, a[HW-1:0]} + {1'b0, b[HW-1:0]} + {{HW{1'b0}}, cin};
    end
    sum   = full_w[W-1:0];
    carry = full_w[W];
    half  = low_w[HW];
  end
endmodule

// File: rtl/acc_alu_logic.sv
module acc_alu_logic #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [1:0]   sel,
  output logic [W-1:0] y
);
  always_comb begin
    case (sel)
      2'd0:    y = a & b;
      2'd1:    y = a | b;
      2'd2:    y = a ^ b;
      default: y = ~a;
    endcase
  end
endmodule

// File: rtl/acc_alu_decadj.sv
module acc_alu_decadj #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic         n_in,
  input  logic         h_in,
  input  logic         c_in,
  output logic [W-1:0] y,
  output logic         c_out
);
  localparam int HW = W / 2;
  localparam logic [W-1:0] LO_FIX = W'(6);
  localparam logic [W-1:0] HI_FIX = W'(6) << HW;
  localparam logic [W-1:0] LO_MAX = W'(9);
  localparam logic [W-1:0] TOP_MAX = (W'(9) << HW) | W'(9);

  logic [W-1:0] fix;

  always_comb begin
    fix   = '0;
    c_out = c_in;
    if (!n_in) begin
      if (h_in || ({{HW{1'b0}}, a[HW-1:0]} > LO_MAX)) fix = fix | LO_FIX;
      if (c_in || (a > TOP_MAX)) begin
        fix   = fix | HI_FIX;
        c_out = 1'b1;
      end
      y = a + fix;
    end else begin
      if (h_in) fix = fix | LO_FIX;
      if (c_in) fix = fix | HI_FIX;
      y = a - fix;
    end
  end
endmodule

// File: rtl/acc_alu.sv
module acc_alu #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [3:0]   op,
  input  logic [W-1:0] acc_in,
  input  logic [W-1:0] opnd_in,
  input  logic         carry_in,
  input  logic [3:0]   flags_in,
  output logic [W-1:0] result,
  output logic         wr_en,
  output logic [3:0]   flags_out
);
  import acc_alu_pkg::*;

  logic         is_sub, use_one, as_cin;
  logic [W-1:0] as_b, as_sum, lg_y, da_y;
  logic         as_h, as_c, da_c;
  logic [1:0]   lg_sel;
  logic [W-1:0] nxt_res;
  logic         nxt_wr;
  logic [3:0]   nxt_flg;

  always_comb begin
    is_sub  = (op == OP_SUB) || (op == OP_SBC) || (op == OP_CMP) || (op == OP_DEC);
    use_one = (op == OP_INC) || (op == OP_DEC);
    as_b    = use_one ? W'(1) : opnd_in;
    as_cin  = ((op == OP_ADC) || (op == OP_SBC)) ? carry_in : 1'b0;
    case (op)
      OP_AND:  lg_sel = 2'd0;
      OP_OR:   lg_sel = 2'd1;
      OP_XOR:  lg_sel = 2'd2;
      default: lg_sel = 2'd3;
    endcase
  end

  acc_alu_addsub #(.W(W)) u_addsub (
    .a(acc_in), .b(as_b), .cin(as_cin), .sub(is_sub),
    .sum(as_sum), .half(as_h), .carry(as_c)
  );

  acc_alu_logic #(.W(W)) u_logic (
    .a(acc_in), .b(opnd_in), .sel(lg_sel), .y(lg_y)
  );

  acc_alu_decadj #(.W(W)) u_decadj (
    .a(acc_in), .n_in(flags_in[FLG_N]), .h_in(flags_in[FLG_H]),
    .c_in(flags_in[FLG_C]), .y(da_y), .c_out(da_c)
  );

  always_comb begin
    nxt_res = acc_in;
    nxt_wr  = 1'b0;
    nxt_flg = flags_in;
    case (op)
      OP_ADD, OP_ADC: begin
        nxt_res = as_sum;
        nxt_wr  = 1'b1;
        nxt_flg = {as_sum == '0, 1'b0, as_h, as_c};
      end
      OP_SUB, OP_SBC: begin
        nxt_res = as_sum;
        nxt_wr  = 1'b1;
        nxt_flg = {as_sum == '0, 1'b1, as_h, as_c};
      end
      OP_CMP: nxt_flg = {as_sum == '0, 1'b1, as_h, as_c};
      OP_AND, OP_OR, OP_XOR: begin
        nxt_res = lg_y;
        nxt_wr  = 1'b1;
        nxt_flg = {lg_y == '0, 1'b0, op == OP_AND, 1'b0};
      end
      OP_INC, OP_DEC: begin
        nxt_res = as_sum;
        nxt_wr  = 1'b1;
        nxt_flg = {as_sum == '0, op == OP_DEC, as_h, flags_in[FLG_C]};
      end
      OP_CPL: begin
        nxt_res = lg_y;
        nxt_wr  = 1'b1;
        nxt_flg = {flags_in[FLG_Z], 1'b1, 1'b1, flags_in[FLG_C]};
      end
      OP_SCF: nxt_flg = {flags_in[FLG_Z], 1'b0, 1'b0, 1'b1};
      OP_CCF: nxt_flg = {flags_in[FLG_Z], 1'b0, 1'b0, ~flags_in[FLG_C]};
      OP_DAA: begin
        nxt_res = da_y;
        nxt_wr  = 1'b1;
        nxt_flg = {da_y == '0, flags_in[FLG_N], 1'b0, da_c};
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      result    <= '0;
      wr_en     <= 1'b0;
      flags_out <= 4'h0;
    end else begin
      result    <= nxt_res;
      wr_en     <= nxt_wr;
      flags_out <= nxt_flg;
    end
  end
endmodule

// File: rtl/acc_alu_chk.sv
module acc_alu_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic [3:0]   op,
  input logic [W-1:0] acc_in,
  input logic [W-1:0] opnd_in,
  input logic         carry_in,
  input logic [3:0]   flags_in,
  input logic [W-1:0] result,
  input logic         wr_en,
  input logic [3:0]   flags_out
);
  p_reset_clear_r11: assert property (@(posedge clk)
    rst |=> (result == '0 && !wr_en && flags_out == 4'h0));

  p_add_n_clear_r1: assert property (@(posedge clk) disable iff (rst)
    (op == 4'd0 || op == 4'd1) |=> (wr_en && !flags_out[2]));

  p_sbc_equal_borrow_r2: assert property (@(posedge clk) disable iff (rst)
    (op == 4'd3 && carry_in && opnd_in == acc_in) |=> (flags_out[0] && flags_out[2]));

  p_cmp_no_write_r3: assert property (@(posedge clk) disable iff (rst)
    (op == 4'd4) |=> (!wr_en && result == $past(acc_in) && flags_out[2]));

  p_and_result_r4: assert property (@(posedge clk) disable iff (rst)
    (op == 4'd5) |=> (result == $past(acc_in & opnd_in) && flags_out[1:0] == 2'b10));

  p_incdec_keep_c_r5: assert property (@(posedge clk) disable iff (rst)
    (op == 4'd8 || op == 4'd9) |=> (flags_out[0] == $past(flags_in[0])));

  p_cpl_r6: assert property (@(posedge clk) disable iff (rst)
    (op == 4'd10) |=> (result == ~$past(acc_in) && flags_out[3] == $past(flags_in[3])
                       && flags_out[0] == $past(flags_in[0])));

  p_scf_r7: assert property (@(posedge clk) disable iff (rst)
    (op == 4'd11) |=> (!wr_en && flags_out[2:0] == 3'b001));

  p_daa_h_clear_r8: assert property (@(posedge clk) disable iff (rst)
    (op == 4'd13) |=> (wr_en && !flags_out[1]));

  p_daa_sub_keep_c_r9: assert property (@(posedge clk) disable iff (rst)
    (op == 4'd13 && flags_in[2]) |=> (flags_out[0] == $past(flags_in[0])));

  p_unused_pass_r10: assert property (@(posedge clk) disable iff (rst)
    (op[3:1] == 3'b111) |=> (!wr_en && result == $past(acc_in)
                             && flags_out == $past(flags_in)));
endmodule

bind acc_alu acc_alu_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .op(op), .acc_in(acc_in), .opnd_in(opnd_in),
  .carry_in(carry_in), .flags_in(flags_in), .result(result),
  .wr_en(wr_en), .flags_out(flags_out)
);

// File: tb/acc_alu_test.sv
module acc_alu_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] op = 4'd0;
  logic [7:0] acc_in = 8'd0;
  logic [7:0] opnd_in = 8'd0;
  logic       carry_in = 1'b0;
  logic [3:0] flags_in = 4'd0;
  logic [7:0] result;
  logic       wr_en;
  logic [3:0] flags_out;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  acc_alu uut (
    .clk(clk), .rst(rst), .op(op), .acc_in(acc_in), .opnd_in(opnd_in),
    .carry_in(carry_in), .flags_in(flags_in), .result(result),
    .wr_en(wr_en), .flags_out(flags_out)
  );

  function automatic string tag_of(input int o, input logic [3:0] f);
    case (o)
      0, 1:    return "R1";
      2, 3:    return "R2";
      4:       return "R3";
      5, 6, 7: return "R4";
      8, 9:    return "R5";
      10:      return "R6";
      11, 12:  return "R7";
      13:      return f[2] ? "R9" : "R8";
      default: return "R10";
    endcase
  endfunction

  // Expected {result, wr_en, flags} from the requirement text
  function automatic logic [12:0] model(input int o, input int a, input int b,
                                        input int ci, input logic [3:0] f);
    int r, c, adj;
    logic [7:0] y;
    logic z, n, h, cy, w;
    y = a[7:0]; w = 1'b0; z = f[3]; n = f[2]; h = f[1]; cy = f[0];
    case (o)
      0, 1: begin
        c = (o == 1) ? ci : 0;
        r = a + b + c; y = r[7:0]; w = 1'b1;
        z = (y == 0); n = 1'b0; h = ((a % 16) + (b % 16) + c) > 15; cy = r > 255;
      end
      2, 3, 4: begin
        c = (o == 3) ? ci : 0;
        r = a - b - c;
        z = (r[7:0] == 0); n = 1'b1; h = (a % 16) < ((b % 16) + c); cy = a < (b + c);
        if (o != 4) begin y = r[7:0]; w = 1'b1; end
      end
      5: begin y = a[7:0] & b[7:0]; w = 1'b1; z = (y == 0); n = 0; h = 1; cy = 0; end
      6: begin y = a[7:0] | b[7:0]; w = 1'b1; z = (y == 0); n = 0; h = 0; cy = 0; end
      7: begin y = a[7:0] ^ b[7:0]; w = 1'b1; z = (y == 0); n = 0; h = 0; cy = 0; end
      8: begin r = a + 1; y = r[7:0]; w = 1'b1; z = (y == 0); n = 0; h = (a % 16) == 15; end
      9: begin r = a + 255; y = r[7:0]; w = 1'b1; z = (y == 0); n = 1; h = (a % 16) == 0; end
      10: begin y = ~a[7:0]; w = 1'b1; n = 1; h = 1; end
      11: begin n = 0; h = 0; cy = 1; end
      12: begin n = 0; h = 0; cy = ~f[0]; end
      13: begin
        adj = 0;
        if (!f[2]) begin
          if (f[1] || (a % 16) > 9) adj += 6;
          if (f[0] || a > 153) begin adj += 96; cy = 1; end
          r = a + adj;
        end else begin
          if (f[1]) adj += 6;
          if (f[0]) adj += 96;
          r = a - adj;
        end
        y = r[7:0]; w = 1'b1; z = (y == 0); h = 0;
      end
      default: ;
    endcase
    return {y, w, z, n, h, cy};
  endfunction

  task automatic check(input string tag, input logic [12:0] exp);
    checks++;
    if ({result, wr_en, flags_out} !== exp) begin
      errors++;
      $display("FAIL %s op=%0d acc=%02h opnd=%02h ci=%0d f=%h: got res=%02h wr=%0d fl=%h exp res=%02h wr=%0d fl=%h",
               tag, op, acc_in, opnd_in, carry_in, flags_in, result, wr_en, flags_out,
               exp[12:5], exp[4], exp[3:0]);
    end
  endtask

  // R12: inputs applied after a falling edge appear after the next rising edge
  task automatic apply(input int o, input int a, input int b, input int ci, input int f);
    logic [12:0] exp;
    @(negedge clk);
    op = o[3:0]; acc_in = a[7:0]; opnd_in = b[7:0]; carry_in = ci[0]; flags_in = f[3:0];
    exp = model(o, a, b, ci, f[3:0]);
    @(posedge clk);
    #1;
    check(tag_of(o, f[3:0]), exp);
  endtask

  initial begin
    int corner[8];
    corner = '{0, 1, 15, 16, 127, 128, 153, 255};
    rst = 1'b1;
    op = 4'd0; acc_in = 8'hA5; opnd_in = 8'h5A; flags_in = 4'hF;
    @(posedge clk); @(posedge clk); #1;
    check("R11", 13'd0);
    @(negedge clk); rst = 1'b0;

    // Two-operand codes: all accumulators against corner operands
    for (int o = 0; o < 8; o++)
      for (int a = 0; a < 256; a++)
        for (int k = 0; k < 8; k++)
          apply(o, a, corner[k], (a + k) % 2, (a + k) % 16);

    // Single-operand codes: all accumulators against every flag nibble
    for (int o = 8; o < 16; o++)
      for (int a = 0; a < 256; a++)
        for (int f = 0; f < 16; f++)
          apply(o, a, 255 - a, f % 2, f);

    // R12: a decimal-adjust after a prior add in back-to-back cycles
    apply(0, 8'h45, 8'h38, 0, 0);
    apply(13, 8'h7D, 0, 0, 4'b0000);
    // R11: reset mid-run clears outputs again
    @(negedge clk); rst = 1'b1; op = 4'd5; acc_in = 8'hFF; opnd_in = 8'hFF;
    @(posedge clk); #1;
    check("R11", 13'd0);
    rst = 1'b0;

    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #1900000;
    if (!done) begin
      done = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog: run did not complete, got timeout exp completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule